// File: doc/BRIEF.md
# Keyed Index/Data Configuration Space

This block provides a byte-wide configuration space reached through a pair of adjacent host ports. Port 0 is the index port, which names a register. Port 1, the data port, reads or writes the register that the index port names. The space stays closed until the host writes a fixed four-byte key to the index port. Until then every read returns 0xFF and data writes have no effect.

Once the space is open, it holds three groups of registers. The first is a logical-device select register. The second is a set of read-only identification registers. The third is a bank of registers for each logical device, holding an enable bit and a 16-bit base address. Register 0x07 chooses which bank appears at indexes 0x30 and above.

The block sends the current device selection, every device's enable bit and every device's base address to the downstream function blocks. A two-write exit sequence closes the space again.

Top module: `cfgport_unlock`

## Requirements
- R1: The space opens (`cfg_unlocked` goes high) in the cycle after the fourth of the index-port writes 0x87, 0x01, 0x55, 0x55, made in that order. Data-port writes and reads between those writes do not disturb the sequence.
- R2: While the space is closed, an index-port write whose byte differs from the next expected key byte sends the sequence back to its start. The mismatching byte itself is not taken as a first key byte, so 0x87, 0x87, 0x01, 0x55, 0x55 leaves the space closed.
- R3: While the space is closed, reads of either port return 0xFF. Data-port writes change no register and no output.
- R4: Writing 0x02 to the index port and then 0x02 to the data port closes the space in the next cycle. Any other value written at index 0x02 leaves the space open.
- R5: While the space is open, an index-port write stores the index, an index-port read returns it, and the stored index persists across closing and reopening the space.
- R6: Index 0x07 holds the selected device number. It is readable and writable, and it drives `sel_ldn`.
- R7: Index 0x20 reads the high byte of `CHIP_ID` and index 0x21 reads its low byte. Index 0x22 reads `CHIP_REV` in bits 3:0 with zeros above. Writes to these three indexes are discarded.
- R8: Index 0x30 reads and writes the enable bit of the selected device in bit 0, with the other bits reading as zero. Device i's enable bit drives `dev_active[i]`.
- R9: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base address. Device i's base address drives `dev_base[16*i+15:16*i]`.
- R10: When the selected device number is NUM_LDN or more, bank indexes read 0x00 and bank writes are ignored. Unassigned indexes read 0x00.
- R11: After reset the space is closed, the stored index and the selected device are 0, and every enable bit and base address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational from the current state |
| cfg_unlocked | output | 1 | The configuration space is open |
| sel_ldn | output | 8 | Selected logical device number |
| dev_active | output | NUM_LDN | Enable bit of each device |
| dev_base | output | 16*NUM_LDN | Base address of each device, device 0 in the low bits |

## Verification
The assertions assume that the host inputs are stable and defined whenever `bus_valid` is high, and that one access completes in one cycle. The read properties also assume that a read is judged on the combinational `bus_rdata` of the cycle in which it is presented.

The stimulus drives every access on the falling edge and holds it for a full cycle. It drops `bus_valid` between accesses. Random traffic injects the key sequence and the exit sequence often enough to spend long stretches in both the closed and the open state. Device numbers are drawn past NUM_LDN so that the unmapped-bank path is reached.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_B3 = 8'h55;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE_H = 8'h60;
  localparam logic [7:0] IDX_BASE_L = 8'h61;
  localparam logic [7:0] EXIT_CODE  = 8'h02;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_GOT1,
    KS_GOT2,
    KS_GOT3,
    KS_OPEN
  } key_state_e;
endpackage

// File: rtl/cfgport_key_fsm.sv
module cfgport_key_fsm
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       unlocked
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_IDLE: if (idx_wr) state_d = (wdata == KEY_B0) ? KS_GOT1 : KS_IDLE;
      KS_GOT1: if (idx_wr) state_d = (wdata == KEY_B1) ? KS_GOT2 : KS_IDLE;
      KS_GOT2: if (idx_wr) state_d = (wdata == KEY_B2) ? KS_GOT3 : KS_IDLE;
      KS_GOT3: if (idx_wr) state_d = (wdata == KEY_B3) ? KS_OPEN : KS_IDLE;
      KS_OPEN: if (exit_req) state_d = KS_IDLE;
      default: state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/cfgport_ldn_bank.sv
module cfgport_ldn_bank
  import cfgport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bank_wr,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] base
);
  logic        act_en, hi_en, lo_en;
  logic        act_d;
  logic [15:0] base_d;

  always_comb begin
    act_en = bank_wr && (idx == IDX_ACT);
    hi_en  = bank_wr && (idx == IDX_BASE_H);
    lo_en  = bank_wr && (idx == IDX_BASE_L);
    act_d  = act_en ? wdata[0] : active;
    base_d = base;
    if (hi_en) base_d[15:8] = wdata;
    if (lo_en) base_d[7:0]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= 16'h0000;
    end else begin
      if (act_en)         active <= act_d;
      if (hi_en || lo_en) base   <= base_d;
    end
  end
endmodule

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
#(
  parameter int          NUM_LDN  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h5A31,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic                 bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 cfg_unlocked,
  output logic [7:0]           sel_ldn,
  output logic [NUM_LDN-1:0]   dev_active,
  output logic [16*NUM_LDN-1:0] dev_base
);
  localparam int BASE_W = 16 * NUM_LDN;

  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       idx_wr_any, idx_wr_open, data_wr_open;
  logic       ldn_en, exit_req;
  logic       bank_hit;
  logic       act_sel;
  logic [15:0] base_sel;

  always_comb begin
    idx_wr_any   = bus_valid && bus_write && !bus_addr;
    idx_wr_open  = idx_wr_any && cfg_unlocked;
    data_wr_open = bus_valid && bus_write && bus_addr && cfg_unlocked;
    ldn_en       = data_wr_open && (idx_q == IDX_LDN);
    exit_req     = data_wr_open && (idx_q == IDX_CTRL) && (bus_wdata == EXIT_CODE);
  end

  cfgport_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr_any && !cfg_unlocked),
    .wdata    (bus_wdata),
    .exit_req (exit_req),
    .unlocked (cfg_unlocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_wr_open) idx_q <= bus_wdata;
      if (ldn_en)      ldn_q <= bus_wdata;
    end
  end

  assign sel_ldn = ldn_q;

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
    logic       bank_wr;
    logic [15:0] base_w;
    assign bank_wr = data_wr_open && (ldn_q == 8'(g));
    cfgport_ldn_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .bank_wr (bank_wr),
      .idx     (idx_q),
      .wdata   (bus_wdata),
      .active  (dev_active[g]),
      .base    (base_w)
    );
    assign dev_base[16*g +: 16] = base_w;
  end

  always_comb begin
    bank_hit = 1'b0;
    act_sel  = 1'b0;
    base_sel = 16'h0000;
    for (int i = 0; i < NUM_LDN; i++) begin
      if (ldn_q == 8'(i)) begin
        bank_hit = 1'b1;
        act_sel  = dev_active[i];
        base_sel = dev_base[16*i +: 16];
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (!cfg_unlocked) begin
      bus_rdata = 8'hFF;
    end else if (!bus_addr) begin
      bus_rdata = idx_q;
    end else begin
      unique case (idx_q)
        IDX_LDN:    bus_rdata = ldn_q;
        IDX_ID_HI:  bus_rdata = CHIP_ID[15:8];
        IDX_ID_LO:  bus_rdata = CHIP_ID[7:0];
        IDX_REV:    bus_rdata = {4'h0, CHIP_REV};
        IDX_ACT:    bus_rdata = bank_hit ? {7'b0, act_sel} : 8'h00;
        IDX_BASE_H: bus_rdata = bank_hit ? base_sel[15:8] : 8'h00;
        IDX_BASE_L: bus_rdata = bank_hit ? base_sel[7:0] : 8'h00;
        default:    bus_rdata = 8'h00;
      endcase
    end
  end

  logic unused_w;
  assign unused_w = ^BASE_W;
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int          NUM_LDN = 4,
  parameter logic [15:0] CHIP_ID = 16'h5A31
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic                  bus_addr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  cfg_unlocked,
  input logic [7:0]            sel_ldn,
  input logic [NUM_LDN-1:0]    dev_active,
  input logic [16*NUM_LDN-1:0] dev_base,
  input logic [7:0]            cfg_index
);
  AST_UNLOCK_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(bus_valid && bus_write && !bus_addr && bus_wdata == 8'h55)); // R1

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && bus_valid && !bus_write) |-> bus_rdata == 8'hFF); // R3

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_unlocked) |-> ($stable(dev_active) && $stable(dev_base) && $stable(sel_ldn))); // R3

  AST_EXIT_BY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(bus_valid && bus_write && bus_addr &&
                                  bus_wdata == 8'h02 && cfg_index == 8'h02)); // R4

  AST_LDN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && bus_valid && bus_write && bus_addr && cfg_index == 8'h07)
      |=> sel_ldn == $past(bus_wdata)); // R6

  AST_ID_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && bus_valid && !bus_write && bus_addr && cfg_index == 8'h20)
      |-> bus_rdata == CHIP_ID[15:8]); // R7
endmodule

bind cfgport_unlock cfgport_checker #(.NUM_LDN(NUM_LDN), .CHIP_ID(CHIP_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .cfg_unlocked (cfg_unlocked),
  .sel_ldn      (sel_ldn),
  .dev_active   (dev_active),
  .dev_base     (dev_base),
  .cfg_index    (idx_q)
);

// File: tb/test_cfgport_unlock.sv
module test_cfgport_unlock;
  localparam int          NUM_LDN  = 4;
  localparam logic [15:0] CHIP_ID  = 16'h5A31;
  localparam logic [3:0]  CHIP_REV = 4'h3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_unlocked;
  logic [7:0] sel_ldn;
  logic [NUM_LDN-1:0] dev_active;
  logic [16*NUM_LDN-1:0] dev_base;

  int checks = 0;
  int errors = 0;

  // model state
  bit         m_open;
  int         m_pos;
  logic [7:0] m_idx, m_ldn;
  logic       m_act [NUM_LDN];
  logic [15:0] m_base [NUM_LDN];

  always #4 clk = ~clk;

  cfgport_unlock #(.NUM_LDN(NUM_LDN), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) i_cfgport_unlock (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_unlocked(cfg_unlocked), .sel_ldn(sel_ldn), .dev_active(dev_active),
    .dev_base(dev_base)
  );

  function automatic logic [7:0] key_byte(int p);
    case (p)
      0: return 8'h87;
      1: return 8'h01;
      default: return 8'h55;
    endcase
  endfunction

  function automatic logic [7:0] model_read(bit addr);
    bit hit;
    hit = (m_ldn < NUM_LDN);
    if (!m_open) return 8'hFF;
    if (!addr) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP_ID[15:8];
      8'h21: return CHIP_ID[7:0];
      8'h22: return {4'h0, CHIP_REV};
      8'h30: return hit ? {7'b0, m_act[m_ldn[1:0]]} : 8'h00;
      8'h60: return hit ? m_base[m_ldn[1:0]][15:8] : 8'h00;
      8'h61: return hit ? m_base[m_ldn[1:0]][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_open = 0; m_pos = 0; m_idx = 8'h00; m_ldn = 8'h00;
    for (int i = 0; i < NUM_LDN; i++) begin m_act[i] = 1'b0; m_base[i] = 16'h0; end
  endtask

  task automatic model_write(bit addr, logic [7:0] d);
    bit hit;
    hit = (m_ldn < NUM_LDN);
    if (!m_open) begin
      if (!addr) begin
        if (d == key_byte(m_pos)) begin
          m_pos++;
          if (m_pos == 4) begin m_open = 1; m_pos = 0; end
        end else m_pos = 0;
      end
    end else if (!addr) begin
      m_idx = d;
    end else begin
      case (m_idx)
        8'h02: if (d == 8'h02) m_open = 0;
        8'h07: m_ldn = d;
        8'h30: if (hit) m_act[m_ldn[1:0]] = d[0];
        8'h60: if (hit) m_base[m_ldn[1:0]][15:8] = d;
        8'h61: if (hit) m_base[m_ldn[1:0]][7:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    logic [16*NUM_LDN-1:0] eb;
    logic [NUM_LDN-1:0] ea;
    for (int i = 0; i < NUM_LDN; i++) begin ea[i] = m_act[i]; eb[16*i +: 16] = m_base[i]; end
    check(cfg_unlocked == m_open, req, 64'(cfg_unlocked), 64'(m_open));
    check(sel_ldn == m_ldn && dev_active == ea && dev_base == eb, req,
          {sel_ldn, 4'h0, dev_active, dev_base[47:0]}, {m_ldn, 4'h0, ea, eb[47:0]});
  endtask

  task automatic wr(bit addr, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = addr; bus_wdata = d;
    @(posedge clk);
    model_write(addr, d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(bit addr, string req);
    logic [7:0] exp;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = addr; bus_wdata = 8'h00;
    #1;
    exp = model_read(addr);
    check(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic unlock();
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    wr(0, idx); wr(1, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, string req);
    wr(0, idx); rd(1, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check_outputs("R11 reset");
    rd(0, "R3 locked index read");
    rd(1, "R3 locked data read");

    // R3: data writes while locked ignored
    wr(1, 8'h5A); check_outputs("R3 locked data write");
    // R2: repeated first byte breaks sequence
    wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    check(cfg_unlocked == 1'b0, "R2 87 87 01 55 55", 64'(cfg_unlocked), 64'd0);
    // R2: wrong third byte then full key; R1 data traffic mid-key
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h56);
    wr(0, 8'h87); wr(1, 8'h33); rd(1, "R1 read mid key"); wr(0, 8'h01); wr(0, 8'h55);
    check(cfg_unlocked == 1'b0, "R1 three of four", 64'(cfg_unlocked), 64'd0);
    wr(0, 8'h55);
    check(cfg_unlocked == 1'b1, "R1 unlock", 64'(cfg_unlocked), 64'd1);
    rd(0, "R5 index readback after unlock");
    // R7
    reg_rd(8'h20, "R7 id high"); reg_rd(8'h21, "R7 id low"); reg_rd(8'h22, "R7 revision");
    reg_wr(8'h20, 8'h00); reg_wr(8'h22, 8'hFF);
    reg_rd(8'h20, "R7 id write discarded"); reg_rd(8'h22, "R7 rev write discarded");
    // R6/R8/R9 per device
    for (int i = 0; i < NUM_LDN; i++) begin
      reg_wr(8'h07, 8'(i));
      reg_wr(8'h30, 8'hFF - 8'(i));
      reg_wr(8'h60, 8'h10 + 8'(i));
      reg_wr(8'h61, 8'hA0 + 8'(i));
    end
    check_outputs("R9 bases after setup");
    reg_wr(8'h07, 8'd2);
    reg_rd(8'h07, "R6 ldn read");
    reg_rd(8'h30, "R8 active read"); reg_rd(8'h60, "R9 base high"); reg_rd(8'h61, "R9 base low");
    // R10
    reg_wr(8'h07, 8'd9);
    reg_wr(8'h30, 8'h01); reg_wr(8'h60, 8'hEE);
    check_outputs("R10 out of range write");
    reg_rd(8'h30, "R10 out of range read"); reg_rd(8'h45, "R10 unassigned index");
    // R4
    reg_wr(8'h02, 8'h03);
    check(cfg_unlocked == 1'b1, "R4 wrong exit value", 64'(cfg_unlocked), 64'd1);
    wr(1, 8'h02);
    check(cfg_unlocked == 1'b0, "R4 exit", 64'(cfg_unlocked), 64'd0);
    reg_wr(8'h30, 8'h00); check_outputs("R3 write after exit");
    unlock();
    rd(0, "R5 index persists");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom % 40;
      if (sel == 0) unlock();
      else if (sel == 1) reg_wr(8'h02, 8'h02);
      else if (sel < 14) begin
        logic [7:0] ix;
        case ($urandom % 9)
          0: ix = 8'h07; 1: ix = 8'h20; 2: ix = 8'h21; 3: ix = 8'h22;
          4: ix = 8'h30; 5: ix = 8'h60; 6: ix = 8'h61; 7: ix = 8'h02;
          default: ix = 8'($urandom);
        endcase
        wr(0, ix);
      end else if (sel < 24) begin
        logic [7:0] d;
        d = (m_idx == 8'h07) ? 8'($urandom % 6) : 8'($urandom);
        if (m_idx == 8'h02 && d == 8'h02) d = 8'h04;
        wr(1, d);
      end else if (sel < 28) wr(0, key_byte($urandom % 3));
      else rd(sel[0], "R5 R8 R9 random read");
      if (n % 8 == 0) check_outputs("R6 R8 R9 random outputs");
    end

    // R11 reset mid-run
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk); check_outputs("R11 second reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule